// File: doc/BRIEF.md
# Output Compare Power-State Controller

An eight-channel output compare wrapper that decides, cycle by cycle, whether each channel's compare logic advances or stands still. The decision follows the device power state (running, idle, sleeping, or a stopped system clock). Each channel either toggles its pin on an externally detected compare match or produces a duty-cycle waveform. The waveform comes from comparing a shared external timer count against a per-channel duty value. That duty value is reloaded at timer rollover.

The block also decides who owns each pin. An enabled channel drives its pin as an output. A disabled channel hands value and direction back to the general-purpose port latch and direction bits. Two shared fault inputs each serve one half of the channels and act on channels in fault-protected duty mode. A fault forces the pin low and sets a sticky flag. Faults are still honoured while the compare logic is halted.

Top module: `oc_power_ctl`

## Requirements
- R1: While `rst_n` is low, all internal compare state and fault flags are cleared. Disabled channels show `lat_i`/`tris_i` on their pins, and `flt_o` is zero.
- R2: For a disabled channel k, `pin_o[k]` equals `lat_i[k]` and `pin_dir_o[k]` equals `tris_i[k]` (direction 1 = input).
- R3: For an enabled channel, `pin_dir_o[k]` is 0 (output).
- R4: Mode code 2'b00 (field `mode_i[2k+1:2k]`) is toggle mode. A `match_i[k]` pulse sampled at a clock edge of a running channel inverts `pin_o[k]` after that edge.
- R5: Mode codes 2'b01 and 2'b11 are duty mode, and 2'b10 is duty mode with fault protection. At each edge of a running channel, `pin_o[k]` becomes 1 when `tmr_cnt_i` is below the active duty. The active duty takes `duty_i[k*W +: W]` only at an edge where `tmr_roll_i` is high, and that new value already applies at that edge.
- R6: While `sleep_i` is 1 or `sys_ce_i` is 0, every channel holds its pin level and internal state. Match pulses and duty reloads are ignored, and operation resumes from the held state afterwards.
- R7: In idle (`idle_i`=1), a channel whose `ch_sidl_i[k]` is 1 halts exactly as in sleep.
- R8: In idle with `ch_sidl_i[k]`=0, the channel runs only if `tb_sidl_i` is 0; otherwise it halts.
- R9: A fault is honoured for channel k only if it is enabled in mode 2'b10, its fault input is 1 and that input's direction bit is 1 (input). An honoured fault drives `pin_o[k]` low in the same cycle and sets `flt_o[k]` at the next edge. Otherwise the fault has no effect.
- R10: `fault_a_i`/`fdir_a_i` serve channels 0 to 3, and `fault_b_i`/`fdir_b_i` serve channels 4 to 7.
- R11: `flt_o[k]` stays set, keeping the pin low, until an `flt_clr_i[k]` pulse while the fault is absent. Faults are honoured and flags set during sleep and idle.
- R12: A disabled, running channel clears its output state, so a re-enabled channel starts driving low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_ce_i | input | 1 | System clock enable; 0 halts all channels |
| sleep_i | input | 1 | Device sleep indication |
| idle_i | input | 1 | Device idle indication |
| tb_sidl_i | input | 1 | Time base stops in idle |
| ch_en_i | input | NCH | Channel enables |
| ch_sidl_i | input | NCH | Per-channel stop-in-idle |
| mode_i | input | 2*NCH | Per-channel mode, 2 bits each |
| match_i | input | NCH | Compare match pulses |
| tmr_cnt_i | input | W | Shared timer count |
| tmr_roll_i | input | 1 | Timer period rollover pulse |
| duty_i | input | NCH*W | Per-channel duty values |
| fault_a_i | input | 1 | Fault input for lower half |
| fault_b_i | input | 1 | Fault input for upper half |
| fdir_a_i | input | 1 | Direction bit of fault A pin (1 = input) |
| fdir_b_i | input | 1 | Direction bit of fault B pin (1 = input) |
| flt_clr_i | input | NCH | Software clear of fault flags |
| lat_i | input | NCH | Port latch values |
| tris_i | input | NCH | Port direction bits (1 = input) |
| pin_o | output | NCH | Pin values |
| pin_dir_o | output | NCH | Pin directions (1 = input) |
| flt_o | output | NCH | Sticky fault flags |

## Verification
Fault forcing and power-state halting can land in the same cycle: the compare logic is frozen while the fault path must still act. The bench holds a fault-protected channel high, enters sleep, and then raises its group's fault. It expects the pin to drop in that same cycle and the flag to appear at the next edge, while the frozen compare state shows up again once the flag is cleared. A clear pulse that coincides with a still-present fault is also provoked, and the flag is expected to survive it.

// File: rtl/oc_power_ctl.sv
module oc_power_ctl #(
  parameter int NCH = 8,
  parameter int W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_ce_i,
  input  logic             sleep_i,
  input  logic             idle_i,
  input  logic             tb_sidl_i,
  input  logic [NCH-1:0]   ch_en_i,
  input  logic [NCH-1:0]   ch_sidl_i,
  input  logic [2*NCH-1:0] mode_i,
  input  logic [NCH-1:0]   match_i,
  input  logic [W-1:0]     tmr_cnt_i,
  input  logic             tmr_roll_i,
  input  logic [NCH*W-1:0] duty_i,
  input  logic             fault_a_i,
  input  logic             fault_b_i,
  input  logic             fdir_a_i,
  input  logic             fdir_b_i,
  input  logic [NCH-1:0]   flt_clr_i,
  input  logic [NCH-1:0]   lat_i,
  input  logic [NCH-1:0]   tris_i,
  output logic [NCH-1:0]   pin_o,
  output logic [NCH-1:0]   pin_dir_o,
  output logic [NCH-1:0]   flt_o
);

  localparam int HALF = NCH / 2;

  wire fa = fault_a_i & fdir_a_i;
  wire fb = fault_b_i & fdir_b_i;
  wire awake = sys_ce_i & ~sleep_i;

  logic [NCH-1:0] out_q, flag_q, run, hit;
  logic [W-1:0]   dact [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    wire [1:0]   md   = mode_i[2*k +: 2];
    wire         pwm  = (md != 2'b00);
    wire         fmd  = (md == 2'b10);
    wire [W-1:0] dnew = duty_i[k*W +: W];
    wire [W-1:0] dsel = tmr_roll_i ? dnew : dact[k];
    wire         fin  = (k < HALF) ? fa : fb;

    assign run[k] = awake & ~(idle_i & (ch_sidl_i[k] | tb_sidl_i));
    assign hit[k] = ch_en_i[k] & fmd & fin;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[k] <= 1'b0;
        dact[k]  <= '0;
      end else if (run[k]) begin
        if (!ch_en_i[k]) out_q[k] <= 1'b0;
        else if (pwm) begin
          if (tmr_roll_i) dact[k] <= dnew;
          out_q[k] <= (tmr_cnt_i < dsel);
        end else if (match_i[k]) out_q[k] <= ~out_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[k] <= 1'b0;
      else if (hit[k])     flag_q[k] <= 1'b1;
      else if (flt_clr_i[k]) flag_q[k] <= 1'b0;
    end

    wire force_lo = hit[k] | flag_q[k];
    assign pin_o[k]     = ch_en_i[k] ? (out_q[k] & ~force_lo) : lat_i[k];
    assign pin_dir_o[k] = ch_en_i[k] ? 1'b0 : tris_i[k];
    assign flt_o[k]     = flag_q[k];

    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run[k] |=> $stable(out_q[k]));

    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run[k] && ch_en_i[k] && !pwm && match_i[k]) |=> (out_q[k] != $past(out_q[k])));

    p_duty_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(run[k] && ch_en_i[k] && pwm && tmr_roll_i) |=> $stable(dact[k]));

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> flt_o[k]);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_o[k] && !flt_clr_i[k]) |=> flt_o[k]);

    p_fault_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en_i[k] && flt_o[k]) |-> !pin_o[k]);
  end

endmodule

// File: tb/tb_oc_power_ctl.sv
module tb_oc_power_ctl;
  localparam int NCH = 8;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_ce_i = 1'b1, sleep_i = 1'b0, idle_i = 1'b0, tb_sidl_i = 1'b0;
  logic [NCH-1:0] ch_en_i = '0, ch_sidl_i = '0, match_i = '0, flt_clr_i = '0;
  logic [2*NCH-1:0] mode_i = 16'h0824;
  logic [W-1:0] tmr_cnt_i = '0;
  logic tmr_roll_i = 1'b0;
  logic [NCH*W-1:0] duty_i = '0;
  logic fault_a_i = 1'b0, fault_b_i = 1'b0, fdir_a_i = 1'b0, fdir_b_i = 1'b0;
  logic [NCH-1:0] lat_i = 8'hA5, tris_i = 8'h3C;
  logic [NCH-1:0] pin_o, pin_dir_o, flt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  oc_power_ctl #(.NCH(NCH), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .sys_ce_i(sys_ce_i), .sleep_i(sleep_i),
    .idle_i(idle_i), .tb_sidl_i(tb_sidl_i), .ch_en_i(ch_en_i),
    .ch_sidl_i(ch_sidl_i), .mode_i(mode_i), .match_i(match_i),
    .tmr_cnt_i(tmr_cnt_i), .tmr_roll_i(tmr_roll_i), .duty_i(duty_i),
    .fault_a_i(fault_a_i), .fault_b_i(fault_b_i), .fdir_a_i(fdir_a_i),
    .fdir_b_i(fdir_b_i), .flt_clr_i(flt_clr_i), .lat_i(lat_i),
    .tris_i(tris_i), .pin_o(pin_o), .pin_dir_o(pin_dir_o), .flt_o(flt_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse_match(input int k);
    match_i[k] = 1'b1; tick(); match_i[k] = 1'b0; settle();
  endtask

  task automatic t_reset();
    settle();
    chk(pin_o, 8'hA5, "R1 pin");
    chk(pin_dir_o, 8'h3C, "R1 dir");
    chk(flt_o, 8'h00, "R1 flag");
    tick(); rst_n = 1'b1; tick();
    chk(pin_o, 8'hA5, "R2 pin disabled");
    chk(pin_dir_o, 8'h3C, "R2 dir disabled");
  endtask

  task automatic t_toggle();
    ch_en_i[0] = 1'b1; settle();
    chk(pin_dir_o[0], 1'b0, "R3 enabled dir");
    chk(pin_o[0], 1'b0, "R12 starts low");
    pulse_match(0);
    chk(pin_o[0], 1'b1, "R4 toggle high");
    pulse_match(0);
    chk(pin_o[0], 1'b0, "R4 toggle low");
  endtask

  task automatic t_sleep();
    pulse_match(0);
    sleep_i = 1'b1; pulse_match(0);
    chk(pin_o[0], 1'b1, "R6 sleep hold");
    sleep_i = 1'b0; sys_ce_i = 1'b0; pulse_match(0);
    chk(pin_o[0], 1'b1, "R6 clock enable hold");
    sys_ce_i = 1'b1; pulse_match(0);
    chk(pin_o[0], 1'b0, "R6 resume");
  endtask

  task automatic t_idle();
    idle_i = 1'b1; ch_sidl_i[0] = 1'b1; pulse_match(0);
    chk(pin_o[0], 1'b0, "R7 idle stop");
    ch_sidl_i[0] = 1'b0; tb_sidl_i = 1'b1; pulse_match(0);
    chk(pin_o[0], 1'b0, "R8 timebase stops");
    tb_sidl_i = 1'b0; pulse_match(0);
    chk(pin_o[0], 1'b1, "R8 idle runs");
    idle_i = 1'b0; pulse_match(0);
  endtask

  task automatic t_pwm();
    ch_en_i[1] = 1'b1;
    duty_i[1*W +: W] = 16'd10; tmr_cnt_i = 16'd0; tmr_roll_i = 1'b1; tick();
    chk(pin_o[1], 1'b1, "R5 load at roll");
    tmr_roll_i = 1'b0; duty_i[1*W +: W] = 16'd3; tmr_cnt_i = 16'd5; tick();
    chk(pin_o[1], 1'b1, "R5 no load without roll");
    tmr_cnt_i = 16'd12; tick();
    chk(pin_o[1], 1'b0, "R5 count above duty");
    tmr_cnt_i = 16'd0; tmr_roll_i = 1'b1; tick();
    tmr_roll_i = 1'b0; tmr_cnt_i = 16'd5; tick();
    chk(pin_o[1], 1'b0, "R5 new duty active");
    sleep_i = 1'b1; duty_i[1*W +: W] = 16'd20; tmr_cnt_i = 16'd0; tmr_roll_i = 1'b1; tick();
    chk(pin_o[1], 1'b0, "R6 pwm held in sleep");
    sleep_i = 1'b0; tmr_roll_i = 1'b0; tmr_cnt_i = 16'd5; tick();
    chk(pin_o[1], 1'b0, "R6 pending duty not taken");
  endtask

  task automatic t_fault();
    for (int k = 0; k < NCH; k++) duty_i[k*W +: W] = 16'd100;
    ch_en_i[2] = 1'b1; ch_en_i[5] = 1'b1;
    tmr_cnt_i = 16'd0; tmr_roll_i = 1'b1; tick(); tmr_roll_i = 1'b0; settle();
    chk(pin_o[2], 1'b1, "R5 fault-mode pwm high");
    fault_a_i = 1'b1; fdir_a_i = 1'b0; tick();
    chk(pin_o[2], 1'b1, "R9 fault ignored when pin not input");
    chk(flt_o[2], 1'b0, "R9 no flag when pin not input");
    fdir_a_i = 1'b1; settle();
    chk(pin_o[2], 1'b0, "R9 forced low same cycle");
    chk(pin_o[5], 1'b1, "R10 group B untouched by A");
    chk(pin_o[1], 1'b1, "R9 plain pwm ignores fault");
    tick();
    chk(flt_o, 8'h04, "R9 flag set");
    flt_clr_i[2] = 1'b1; tick(); flt_clr_i[2] = 1'b0; settle();
    chk(flt_o[2], 1'b1, "R11 clear ignored while fault present");
    fault_a_i = 1'b0; tick();
    chk(pin_o[2], 1'b0, "R11 flag keeps pin low");
    flt_clr_i[2] = 1'b1; tick(); flt_clr_i[2] = 1'b0; settle();
    chk(flt_o[2], 1'b0, "R11 flag cleared");
    chk(pin_o[2], 1'b1, "R11 pin released");
  endtask

  task automatic t_fault_sleep();
    sleep_i = 1'b1; tick();
    chk(pin_o[5], 1'b1, "R6 held high in sleep");
    fault_b_i = 1'b1; fdir_b_i = 1'b1; settle();
    chk(pin_o[5], 1'b0, "R11 fault forces in sleep");
    chk(pin_o[2], 1'b1, "R10 group A untouched by B");
    tick();
    chk(flt_o, 8'h20, "R11 flag set in sleep");
    fault_b_i = 1'b0; flt_clr_i[5] = 1'b1; tick(); flt_clr_i[5] = 1'b0; settle();
    chk(pin_o[5], 1'b1, "R6 frozen level reappears");
    sleep_i = 1'b0; tick();
  endtask

  task automatic t_disable();
    pulse_match(0);
    chk(pin_o[0], 1'b1, "R4 toggle before disable");
    lat_i = 8'h5A; tris_i = 8'hFF; ch_en_i[0] = 1'b0; settle();
    chk(pin_o[0], 1'b0, "R2 latch value");
    chk(pin_dir_o[0], 1'b1, "R2 direction bit");
    tick(); ch_en_i[0] = 1'b1; settle();
    chk(pin_o[0], 1'b0, "R12 re-enable starts low");
    chk(pin_dir_o[0], 1'b0, "R3 re-enabled output");
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=running exp=done");
    finish_up();
  end

  initial begin
    t_reset();
    t_toggle();
    t_sleep();
    t_idle();
    t_pwm();
    t_fault();
    t_fault_sleep();
    t_disable();
    finish_up();
  end
endmodule